// File: doc/BRIEF.md
# Carry-Generate and Three-Input Adder Unit

This execution unit supports multiword integer arithmetic on a machine with no condition flags. A two-operand add or subtract produces a word result. A carry-generate operation returns, as the value 0 or 1, the carry-out of an add or the borrow of a subtract. The carry is recovered from the operands and the sum alone, so no flag state is kept. A three-operand add then folds that 0/1 value into the next word's sum. Together these give a wide add in a short, flag-free sequence.

A chained mode takes a different route. The first word's add latches its carry-out in a hidden carry register. Each middle-word add consumes that carry and replaces it. The last-word add consumes it and clears it. Each operation writes only its word result, so the register file needs a single write port. Every operation is accepted with a valid strobe, and its result appears one clock later together with an output valid.

Top module: `cga_unit`

## Requirements
- R1: After reset, `out_valid` and `out_result` are 0 and the hidden carry is 0. A chain-middle add (op 6) issued first therefore adds no carry.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. The result of an operation accepted at a clock edge is on `out_result` after that edge.
- R3: Op 0 (add) returns `in_a + in_b` modulo 2^W.
- R4: Op 1 (subtract) returns `in_a - in_b` modulo 2^W.
- R5: Op 2 (add carry-generate) returns 1 when `in_a + in_b` exceeds 2^W - 1, and 0 otherwise.
- R6: Op 3 (subtract borrow-generate) returns 1 when `in_a` is unsigned-less-than `in_b`, and 0 otherwise.
- R7: Op 4 (three-operand add) returns `in_a + in_b + in_c` modulo 2^W. Overflow past W bits is dropped.
- R8: Op 5 (chain first) returns `in_a + in_b` and ignores the hidden carry. It stores the carry-out of that sum in the hidden carry.
- R9: Op 6 (chain middle) returns `in_a + in_b + carry` and stores the new carry-out in the hidden carry.
- R10: Op 7 (chain last) returns `in_a + in_b + carry` and clears the hidden carry.
- R11: Ops 0 to 4, and cycles with `in_valid` low, leave the hidden carry unchanged.
- R12: While `in_valid` is low, `out_result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code, values 0 to 7 as in R3 to R10 |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_c | input | W | Third operand, used by op 4 only |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | W | Registered result |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle valid pipeline;
- that add carry-generate matches a wrapped sum falling below its first operand;
- that borrow-generate matches a wrapped difference rising above its first operand;
- that the result holds while idle;
- that the hidden carry is cleared by a last-word add and left alone by non-chain operations.

The exact arithmetic of every opcode depends on values chosen by the scenarios, so only the bench's scoreboard can confirm it. The same applies to carry propagation across a full 128-bit chained add and a 128-bit flag-free add built from generate and three-operand steps, and to the carry persisting across unrelated operations and idle gaps.

// File: rtl/cga_pkg.sv
package cga_pkg;

  typedef enum logic [2:0] {
    OP_ADD      = 3'd0,
    OP_SUB      = 3'd1,
    OP_GEN_CY   = 3'd2,
    OP_GEN_BW   = 3'd3,
    OP_ADD3     = 3'd4,
    OP_CH_FIRST = 3'd5,
    OP_CH_MID   = 3'd6,
    OP_CH_LAST  = 3'd7
  } cga_op_e;

  // Carry out of the top bit position, recovered from the operand MSBs
  // and the sum MSB: a generate, or a propagate whose sum bit came out 0.
  function automatic logic msb_carry(input logic a_msb, input logic b_msb,
                                     input logic s_msb);
    return (a_msb & b_msb) | ((a_msb | b_msb) & ~s_msb);
  endfunction

  function automatic logic is_chain_load(input cga_op_e op);
    return (op == OP_CH_FIRST) || (op == OP_CH_MID);
  endfunction

endpackage

// File: rtl/cga_arith.sv
module cga_arith
  import cga_pkg::*;
#(
  parameter int W = 32
) (
  input  cga_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);
  localparam int PADW = W - 1;

  logic [W-1:0] sum_ab, diff_ab, sum3, chain_sum;
  logic         cin_used, cy_ab, cy_chain, bw_ab;

  assign cin_used  = (op == OP_CH_MID) || (op == OP_CH_LAST);
  assign sum_ab    = a + b;
  assign diff_ab   = a - b;
  assign sum3      = a + b + c;
  assign chain_sum = a + b + {{PADW{1'b0}}, cin_used & cin};
  assign cy_ab     = msb_carry(a[W-1], b[W-1], sum_ab[W-1]);
  assign cy_chain  = msb_carry(a[W-1], b[W-1], chain_sum[W-1]);
  assign bw_ab     = (a < b);
  assign cout      = cy_chain;

  always_comb begin
    unique case (op)
      OP_ADD:    res = sum_ab;
      OP_SUB:    res = diff_ab;
      OP_GEN_CY: res = {{PADW{1'b0}}, cy_ab};
      OP_GEN_BW: res = {{PADW{1'b0}}, bw_ab};
      OP_ADD3:   res = sum3;
      default:   res = chain_sum;
    endcase
  end
endmodule

// File: rtl/cga_carry_reg.sv
module cga_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (clear) q <= 1'b0;
    else if (load)  q <= d;
  end

  // R10: a last-word add leaves the hidden carry at zero
  p_last_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == 1'b0));

  // R11: with neither load nor clear the carry does not move
  p_carry_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> $stable(q));
endmodule

// File: rtl/cga_unit.sv
module cga_unit
  import cga_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         out_valid,
  output logic [W-1:0] out_result
);
  cga_op_e      op;
  logic [W-1:0] alu_res;
  logic         alu_cout, hid_carry;
  logic         chain_load, chain_clear;

  assign op          = cga_op_e'(in_op);
  assign chain_load  = in_valid && is_chain_load(op);
  assign chain_clear = in_valid && (op == OP_CH_LAST);

  cga_arith #(.W(W)) u_arith (
    .op(op), .a(in_a), .b(in_b), .c(in_c), .cin(hid_carry),
    .res(alu_res), .cout(alu_cout)
  );

  cga_carry_reg u_carry (
    .clk(clk), .rst_n(rst_n), .load(chain_load), .clear(chain_clear),
    .d(alu_cout), .q(hid_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= alu_res;
    end
  end

  // Independent restatements used only by the properties below
  logic [W-1:0] chk_sum, chk_diff;
  logic         gen_cy_req, gen_bw_req;
  assign chk_sum    = in_a + in_b;
  assign chk_diff   = in_a - in_b;
  assign gen_cy_req = in_valid && (op == OP_GEN_CY);
  assign gen_bw_req = in_valid && (op == OP_GEN_BW);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_gen_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_cy_req |=> (out_result == W'($past(chk_sum) < $past(in_a))));

  p_gen_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_bw_req |=> (out_result == W'($past(chk_diff) > $past(in_a))));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
endmodule

// File: tb/cga_unit_tb.sv
module cga_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic         out_valid;
  logic [W-1:0] out_result;

  int checks = 0, failures = 0;
  bit done = 0;
  logic tb_cy = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_res = '0;

  always #2 clk = ~clk;

  cga_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model written from the requirements, using a 33-bit view
  task automatic send(input logic [2:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] c, input string req);
    logic [W:0] wide;
    logic [W-1:0] e;
    case (op)
      3'd0: e = a + b;
      3'd1: e = a - b;
      3'd2: begin wide = {1'b0, a} + {1'b0, b}; e = W'(wide[W]); end
      3'd3: e = W'(a < b);
      3'd4: e = a + b + c;
      3'd5: begin wide = {1'b0, a} + {1'b0, b}; e = wide[W-1:0]; tb_cy = wide[W]; end
      3'd6: begin wide = {1'b0, a} + {1'b0, b} + (W+1)'(tb_cy); e = wide[W-1:0]; tb_cy = wide[W]; end
      default: begin wide = {1'b0, a} + {1'b0, b} + (W+1)'(tb_cy); e = wide[W-1:0]; tb_cy = 1'b0; end
    endcase
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
    exp_q.push_back(e); tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_a = $urandom; in_b = $urandom; in_op = 3'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard on each valid result, checks hold otherwise
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (exp_q.size() == 0) check("R2 unexpected out_valid", W'(1), W'(0));
          else check(tag_q.pop_front(), out_result, exp_q.pop_front());
          last_res = out_result;
        end else begin
          check("R12 hold while idle", out_result, last_res);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [127:0] wa, wb, ws;
  logic [W-1:0] gc;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", W'(out_valid), W'(0));
    check("R1 reset out_result", out_result, '0);
    send(3'd6, 32'd1, 32'd1, '0, "R1 carry clear after reset");
    send(3'd0, 32'hFFFF_FFFF, 32'd2, '0, "R3 add wrap");
    send(3'd0, 32'h1234_5678, 32'h1111_1111, '0, "R3 add");
    send(3'd1, 32'd5, 32'd7, '0, "R4 sub wrap");
    send(3'd1, 32'h9000_0000, 32'h1000_0001, '0, "R4 sub");
    send(3'd2, 32'hFFFF_FFFF, 32'd1, '0, "R5 carry edge 1");
    send(3'd2, 32'hFFFF_FFFE, 32'd1, '0, "R5 carry edge 0");
    send(3'd2, 32'h8000_0000, 32'h8000_0000, '0, "R5 carry msb");
    send(3'd3, 32'd3, 32'd4, '0, "R6 borrow 1");
    send(3'd3, 32'd4, 32'd4, '0, "R6 borrow equal");
    send(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 add3 overflow dropped");
    send(3'd4, 32'd10, 32'd20, 32'd30, "R7 add3");
    idle(2);
    send(3'd5, 32'hFFFF_FFFF, 32'd1, '0, "R8 chain first sets carry");
    send(3'd0, 32'd0, 32'd0, '0, "R3 add between chain ops");
    send(3'd2, 32'd1, 32'd1, '0, "R5 gen between chain ops");
    idle(3);
    send(3'd6, 32'hFFFF_FFFF, 32'd0, '0, "R11 carry kept, R9 mid propagates");
    send(3'd7, 32'd0, 32'd0, '0, "R9 mid carry into R10 last");
    send(3'd6, 32'd0, 32'd0, '0, "R10 last cleared carry");
    send(3'd5, 32'd1, 32'd1, '0, "R8 chain first ignores carry");
    idle(1);
    // 128-bit add through the chain
    wa = 128'hFFFF_FFFF_0123_4567_FFFF_FFFF_FFFF_FFFF;
    wb = 128'h0000_0001_89AB_CDEF_0000_0000_0000_0001;
    ws = wa + wb;
    send(3'd5, wa[31:0],   wb[31:0],   '0, "R8 wide word0");
    send(3'd6, wa[63:32],  wb[63:32],  '0, "R9 wide word1");
    send(3'd6, wa[95:64],  wb[95:64],  '0, "R9 wide word2");
    send(3'd7, wa[127:96], wb[127:96], '0, "R10 wide word3");
    // 128-bit add without the chain: word sum, then generate, then add3
    send(3'd0, wa[31:0], wb[31:0], '0, "R3 flagless word0");
    gc = W'(({1'b0, wa[31:0]} + {1'b0, wb[31:0]}) >> W);
    send(3'd2, wa[31:0], wb[31:0], '0, "R5 flagless carry0");
    send(3'd4, wa[63:32], wb[63:32], gc, "R7 flagless word1");
    idle(2);
    @(negedge clk);
    check("R8 128-bit low word model", ws[31:0], wa[31:0] + wb[31:0]);
    check("R2 scoreboard drained", W'(exp_q.size()), W'(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule